// File: doc/BRIEF.md
# Unsigned Multiply-Accumulate Datapath

This unit is a small DSP datapath. On each accepted operation it multiplies two 16-bit operands as unsigned numbers and combines the product with one of two 40-bit accumulators. There are three operations: overwrite the accumulator with the product, add the product to it, or subtract the product from it. A fractional-mode input doubles the product before it is applied. All accumulator arithmetic wraps modulo 2^40. The unit does not saturate and does not sign-extend.

An operation is presented with `in_valid` for one cycle, together with its code, accumulator select, operands and fractional flag. There is no back-pressure: the unit accepts one operation on every cycle, so there is no ready signal. The new accumulator value appears on `out_acc` one cycle later, with `out_valid` high for exactly that cycle. A separate load port writes an accumulator directly, so that a test can set a starting value. The accumulator being read is always the current registered value, so back-to-back operations on the same accumulator chain without stalls.

Top module: `umac_unit`

## Requirements
- R1: Both operands are zero-extended, and the full 32-bit product is formed (0xFFFF times 0xFFFF gives 0xFFFE0001).
- R2: Op code 2'b00 (store) writes the product, zero-extended to 40 bits, into the selected accumulator.
- R3: Op code 2'b01 (add) writes (accumulator + product) mod 2^40 into the selected accumulator.
- R4: Op code 2'b10 (subtract) writes (accumulator - product) mod 2^40, with no sign extension. Accumulator 0x7F_FFFF_FFFF minus 0x8001 times 0xFFFF gives 0x7F_7FFF_8000.
- R5: When `in_frac` is 1, the product is shifted left by one bit (up to 33 bits) before it is applied, in all three operations. The R4 example then gives 0x7E_FFFF_0001.
- R6: `in_acc_sel` (0 or 1) chooses the accumulator that is read and written. The other accumulator keeps its value.
- R7: When `in_valid` is 0 and `ld_valid` is 1, `ld_data` is written into accumulator `ld_sel` and `out_valid` stays 0. When `in_valid` is 1 in the same cycle, the load is ignored.
- R8: An accepted operation raises `out_valid` in the following cycle, for one cycle only, with `out_acc` equal to the new accumulator value. `out_acc` holds its value when no operation completes.
- R9: A synchronous reset (`rst` high at a clock edge) clears both accumulators, `out_acc` and `out_valid` to zero.
- R10: Op code 2'b11 is reserved. With `in_valid` high it writes no accumulator, produces no `out_valid`, and suppresses any load in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code (00 store, 01 add, 10 subtract, 11 reserved) |
| in_acc_sel | input | 1 | Accumulator select for the operation |
| in_opa | input | 16 | First unsigned operand |
| in_opb | input | 16 | Second unsigned operand |
| in_frac | input | 1 | Fractional mode: double the product |
| ld_valid | input | 1 | Direct accumulator load strobe |
| ld_sel | input | 1 | Accumulator select for the load |
| ld_data | input | 40 | Load value |
| out_valid | output | 1 | One-cycle done pulse |
| out_acc | output | 40 | Updated accumulator value |

## Verification
The hardest cases to reach are the wrap-around boundaries and the conflicts between the load port and the operation strobe. The accumulator has to sit exactly at 0xFF_FFFF_FFFF or at 0 before an add or subtract of one. It also has to hold a large value before a doubled subtract. The stimulus sets these values up through the load port. It then reads an accumulator back by adding a zero product, which shows whether a load, a reserved code or an operation on the other accumulator left the value untouched. A long random phase mixes loads, reserved codes and fractional mode. A behavioural model compares the outputs on every clock.

// File: rtl/umac_pkg.sv
package umac_pkg;
  typedef enum logic [1:0] {
    UMAC_STORE = 2'b00,
    UMAC_ADD   = 2'b01,
    UMAC_SUB   = 2'b10,
    UMAC_RSVD  = 2'b11
  } umac_op_e;
endpackage

// File: rtl/umac_mul.sv
// Unsigned multiplier with optional doubling for fractional mode.
module umac_mul #(
  parameter int OPW = 16,
  parameter int PW  = 2 * OPW + 1
) (
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  input  logic           frac,
  output logic [PW-1:0]  prod
);
  localparam int FULLW = 2 * OPW;

  logic [FULLW-1:0] full;

  always_comb begin
    full = opa * opb;
    if (frac) prod = {full, 1'b0};
    else      prod = {1'b0, full};
  end
endmodule

// File: rtl/umac_alu.sv
// Combines a product with an accumulator value, modulo 2^ACCW.
module umac_alu
  import umac_pkg::*;
#(
  parameter int ACCW = 40,
  parameter int PW   = 33
) (
  input  umac_op_e        op,
  input  logic [ACCW-1:0] acc_in,
  input  logic [PW-1:0]   prod,
  output logic [ACCW-1:0] res
);
  localparam int PADW = ACCW - PW;

  logic [ACCW-1:0] prod_ext;

  always_comb begin
    prod_ext = {{PADW{1'b0}}, prod};
    unique case (op)
      UMAC_STORE: res = prod_ext;
      UMAC_ADD:   res = acc_in + prod_ext;
      UMAC_SUB:   res = acc_in - prod_ext;
      default:    res = acc_in;
    endcase
  end
endmodule

// File: rtl/umac_accbank.sv
// Bank of accumulators with one write port and one read port.
module umac_accbank #(
  parameter int NACC = 2,
  parameter int ACCW = 40,
  parameter int SELW = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [ACCW-1:0] wr_data,
  input  logic [SELW-1:0] rd_sel,
  output logic [ACCW-1:0] rd_data
);
  logic [ACCW-1:0] acc_q [NACC];

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    localparam logic [SELW-1:0] IDX = SELW'(i);

    always_ff @(posedge clk) begin
      if (rst)                        acc_q[i] <= '0;
      else if (wr_en && wr_sel == IDX) acc_q[i] <= wr_data;
    end

    // R6: an accumulator not addressed by the write keeps its value
    a_r6_unselected_hold: assert property (@(posedge clk) disable iff (rst)
      (!wr_en || wr_sel != IDX) |=> $stable(acc_q[i]));

    // R7 / R2: the addressed accumulator takes the written value
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == IDX) |=> acc_q[i] == $past(wr_data));

    // R9: reset clears every accumulator
    a_r9_acc_cleared: assert property (@(posedge clk)
      rst |=> acc_q[i] == '0);
  end

  assign rd_data = acc_q[rd_sel];
endmodule

// File: rtl/umac_unit.sv
// Unsigned multiply-accumulate datapath with two accumulators.
module umac_unit
  import umac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int NACC = 2,
  parameter int SELW = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [SELW-1:0] in_acc_sel,
  input  logic [OPW-1:0]  in_opa,
  input  logic [OPW-1:0]  in_opb,
  input  logic            in_frac,
  input  logic            ld_valid,
  input  logic [SELW-1:0] ld_sel,
  input  logic [ACCW-1:0] ld_data,
  output logic            out_valid,
  output logic [ACCW-1:0] out_acc
);
  localparam int PW = 2 * OPW + 1;

  umac_op_e        op;
  logic            op_go;
  logic [PW-1:0]   prod;
  logic [ACCW-1:0] rd_acc;
  logic [ACCW-1:0] alu_res;
  logic            wr_en;
  logic [SELW-1:0] wr_sel;
  logic [ACCW-1:0] wr_data;

  assign op    = umac_op_e'(in_op);
  assign op_go = in_valid && (op != UMAC_RSVD);

  umac_mul #(.OPW(OPW), .PW(PW)) u_mul (
    .opa (in_opa),
    .opb (in_opb),
    .frac(in_frac),
    .prod(prod)
  );

  // R1: without doubling the product never reaches its top bit
  a_r1_prod_width: assert property (@(posedge clk) disable iff (rst)
    !in_frac |-> prod[PW-1] == 1'b0);

  // R5: a doubled product is always even
  a_r5_frac_even: assert property (@(posedge clk) disable iff (rst)
    in_frac |-> prod[0] == 1'b0);

  umac_alu #(.ACCW(ACCW), .PW(PW)) u_alu (
    .op    (op),
    .acc_in(rd_acc),
    .prod  (prod),
    .res   (alu_res)
  );

  // Operation wins the single write port; load only when no strobe.
  always_comb begin
    wr_en   = op_go || (ld_valid && !in_valid);
    wr_sel  = op_go ? in_acc_sel : ld_sel;
    wr_data = op_go ? alu_res : ld_data;
  end

  umac_accbank #(.NACC(NACC), .ACCW(ACCW), .SELW(SELW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (in_acc_sel),
    .rd_data(rd_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
    end else begin
      out_valid <= op_go;
      if (op_go) out_acc <= alu_res;
    end
  end

  // R8: an accepted operation gives a done pulse in the next cycle
  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != 2'b11) |=> out_valid);

  // R8: no accepted operation means no pulse and a held result
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_op != 2'b11) |=> (!out_valid && $stable(out_acc)));

  // R10: a reserved code never produces a done pulse
  a_r10_rsvd_silent: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b11) |=> !out_valid);

  // R7: a load alone never produces a done pulse
  a_r7_load_silent: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !in_valid) |=> !out_valid);

  // R9: reset clears the output register
  a_r9_out_cleared: assert property (@(posedge clk)
    rst |=> (!out_valid && out_acc == '0));
endmodule

// File: tb/sim_umac_unit.sv
module sim_umac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic        in_acc_sel = 1'b0;
  logic [15:0] in_opa = '0;
  logic [15:0] in_opb = '0;
  logic        in_frac = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_sel = 1'b0;
  logic [39:0] ld_data = '0;
  logic        out_valid;
  logic [39:0] out_acc;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  umac_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_acc_sel(in_acc_sel), .in_opa(in_opa), .in_opb(in_opb),
    .in_frac(in_frac), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_data(ld_data), .out_valid(out_valid), .out_acc(out_acc)
  );

  // Behavioural reference model
  localparam longint unsigned MASK40 = 64'h00FF_FFFF_FFFF;
  longint unsigned m_acc [2];
  bit              exp_valid = 0;
  longint unsigned exp_out = 0;
  string           exp_tag = "R8";

  always @(posedge clk) begin
    longint unsigned p;
    longint unsigned r;
    if (rst) begin
      m_acc[0] = 0; m_acc[1] = 0;
      exp_valid = 0; exp_out = 0; exp_tag = "R9";
    end else begin
      exp_valid = 0;
      if (in_valid && in_op != 2'b11) begin
        p = longint'(in_opa) * longint'(in_opb);
        if (in_frac) p = p * 2;
        case (in_op)
          2'b00:   begin r = p;                   exp_tag = in_frac ? "R5" : "R2"; end
          2'b01:   begin r = m_acc[in_acc_sel] + p; exp_tag = in_frac ? "R5" : "R3"; end
          default: begin r = m_acc[in_acc_sel] - p; exp_tag = in_frac ? "R5" : "R4"; end
        endcase
        r = r & MASK40;
        m_acc[in_acc_sel] = r;
        exp_out = r;
        exp_valid = 1;
      end else if (ld_valid && !in_valid) begin
        m_acc[ld_sel] = ld_data;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%010h expected 0x%010h", tag, act, exp);
    end
  endtask

  // One clock; compare against the model at the following falling edge.
  task automatic cyc();
    @(negedge clk);
    if (!rst) begin
      check(out_valid === exp_valid, "R8", {39'b0, out_valid}, {39'b0, exp_valid});
      check(out_acc === exp_out[39:0], exp_tag, out_acc, exp_out[39:0]);
    end
  endtask

  task automatic idle();
    in_valid = 0; ld_valid = 0;
  endtask

  task automatic op(logic [1:0] o, logic s, logic [15:0] a, logic [15:0] b, logic f);
    in_valid = 1; in_op = o; in_acc_sel = s; in_opa = a; in_opb = b; in_frac = f;
    cyc();
    idle();
  endtask

  task automatic load(logic s, logic [39:0] d);
    ld_valid = 1; ld_sel = s; ld_data = d;
    cyc();
    idle();
  endtask

  // Read an accumulator through the normal interface: add a zero product.
  task automatic readback(logic s, logic [39:0] exp, string tag);
    op(2'b01, s, 16'h0, 16'h0, 1'b0);
    check(out_acc === exp, tag, out_acc, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x%010h expected 0x%010h", 40'd0, 40'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc();
    // R9: reset state
    check(out_valid === 1'b0, "R9", {39'b0, out_valid}, 40'd0);
    check(out_acc === 40'd0, "R9", out_acc, 40'd0);
    readback(1'b0, 40'd0, "R9");
    readback(1'b1, 40'd0, "R9");

    // R1 / R2: full unsigned product stored
    op(2'b00, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0);
    check(out_acc === 40'h00_FFFE_0001, "R1", out_acc, 40'h00_FFFE_0001);
    // R5: doubled product may use 33 bits
    op(2'b00, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1);
    check(out_acc === 40'h01_FFFC_0002, "R5", out_acc, 40'h01_FFFC_0002);

    // R4: subtract example
    load(1'b1, 40'h7F_FFFF_FFFF);
    op(2'b10, 1'b1, 16'h8001, 16'hFFFF, 1'b0);
    check(out_acc === 40'h7F_7FFF_8000, "R4", out_acc, 40'h7F_7FFF_8000);
    // R5: same with fractional mode
    load(1'b1, 40'h7F_FFFF_FFFF);
    op(2'b10, 1'b1, 16'h8001, 16'hFFFF, 1'b1);
    check(out_acc === 40'h7E_FFFF_0001, "R5", out_acc, 40'h7E_FFFF_0001);

    // R3: add wraps at 2^40
    load(1'b0, 40'hFF_FFFF_FFFF);
    op(2'b01, 1'b0, 16'h0001, 16'h0001, 1'b0);
    check(out_acc === 40'd0, "R3", out_acc, 40'd0);
    // R4: subtract wraps below zero
    op(2'b10, 1'b0, 16'h0001, 16'h0001, 1'b0);
    check(out_acc === 40'hFF_FFFF_FFFF, "R4", out_acc, 40'hFF_FFFF_FFFF);

    // R6: accumulator 1 untouched by operations on accumulator 0
    readback(1'b1, 40'h7E_FFFF_0001, "R6");

    // R7: load ignored when an operation is strobed
    in_valid = 1; in_op = 2'b00; in_acc_sel = 0; in_opa = 16'd2; in_opb = 16'd3; in_frac = 0;
    ld_valid = 1; ld_sel = 0; ld_data = 40'h12_3456_789A;
    cyc();
    idle();
    check(out_acc === 40'd6, "R7", out_acc, 40'd6);
    readback(1'b0, 40'd6, "R7");

    // R10: reserved code writes nothing and gives no pulse
    in_valid = 1; in_op = 2'b11; in_acc_sel = 0; in_opa = 16'd5; in_opb = 16'd5;
    ld_valid = 1; ld_sel = 0; ld_data = 40'h55;
    cyc();
    idle();
    check(out_valid === 1'b0, "R10", {39'b0, out_valid}, 40'd0);
    check(out_acc === 40'd6, "R10", out_acc, 40'd6);
    readback(1'b0, 40'd6, "R10");

    // R8: pulse lasts one cycle, result holds
    cyc();
    check(out_valid === 1'b0, "R8", {39'b0, out_valid}, 40'd0);
    check(out_acc === 40'd6, "R8", out_acc, 40'd6);

    // Mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      in_valid   = (k < 7);
      in_op      = 2'($urandom_range(0, 3));
      in_acc_sel = 1'($urandom_range(0, 1));
      in_opa     = 16'($urandom);
      in_opb     = 16'($urandom);
      in_frac    = 1'($urandom_range(0, 1));
      ld_valid   = ($urandom_range(0, 3) == 0);
      ld_sel     = 1'($urandom_range(0, 1));
      ld_data    = {8'($urandom), 32'($urandom)};
      cyc();
    end
    idle();
    cyc();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule